// File: doc/BRIEF.md
# Aliased Set/Clear/Toggle Configuration Register Bank

This block holds three 32-bit configuration registers behind a simple word-addressed bus. The registers are an interrupt-mode register, a filter-enable register and an event-flag register. Each register takes up a group of four word addresses. The first address of the group reads and writes the register directly. The other three addresses are write-only. They change, in a single write, only the bits selected by the write data: one sets those bits, one clears them and one inverts them. Software can therefore change one bit without a read-modify-write sequence.

The event-flag register is special. Hardware event inputs set its bits. Software can read it at its base address and can clear bits only through its clear address. A parameter mask names the implemented bit positions. Bits outside the mask always hold zero. The current register values go out on ports to the pin logic, which lies outside this block.

Top module: `alias_reg_bank`

## Requirements
- R1: A write to a register's base address (group offset 0x0) loads the write data ANDed with the implemented mask. The new value appears on the register's output port after the next rising clock edge.
- R2: A write to group offset 0x4 (set) forces to 1 each implemented bit whose write-data bit is 1. All other bits keep their value.
- R3: A write to group offset 0x8 (clear) forces to 0 each bit whose write-data bit is 1. All other bits keep their value.
- R4: A write to group offset 0xC (toggle) inverts each implemented bit whose write-data bit is 1. All other bits keep their value.
- R5: Bits outside the implemented mask read 0 and are shown as 0 on the output ports, whatever is written to them.
- R6: Read data is registered. A read at a base address returns the register value in the cycle after the read strobe. A read of a set, clear or toggle address returns 0. In any cycle that follows a cycle with no read strobe, the read data is 0.
- R7: The event-flag register, in the group at 0xD0, ignores writes to its base, set and toggle addresses. Only its clear address, 0xD8, changes it.
- R8: Each bit of `evt_i` that is 1 sets the matching implemented flag bit on the next edge. If software clears the same bit in the same cycle, the flag stays 1.
- R9: Reset loads each register with its reset-value parameter ANDed with the implemented mask. The defaults are mode 0, filter 0x000000A5 and flags 0.
- R10: Accesses that change no register: a write to an address outside the three groups (mode at 0xB0, filter at 0xC0, flags at 0xD0), and a write whose address bits [1:0] are not zero. Reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW (8) | Byte address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Registered read data |
| evt_i | input | DW (32) | Hardware event inputs that set flag bits |
| mode_o | output | DW (32) | Interrupt-mode register value |
| filt_o | output | DW (32) | Filter-enable register value |
| flag_o | output | DW (32) | Event-flag register value |

## Verification
Two functions can act in the same cycle: a software clear through the flag register's clear address and a hardware event on `evt_i`. The bench first raises flag bits through events. It then drives a clear write and an event pulse at the same falling edge. Some bits are both cleared and re-raised; others are only cleared. After the edge, the flag port and a base-address read must show the re-raised bits still set and the others cleared.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // Position of an access inside a four-word register group (address bits [3:2]).
    typedef enum logic [1:0] {
        AK_PLAIN = 2'd0,
        AK_SET   = 2'd1,
        AK_CLR   = 2'd2,
        AK_TGL   = 2'd3
    } alias_kind_e;

    // Legal-write masks, indexed by alias_kind_e.
    localparam logic [3:0] AK_ALLOW_ALL = 4'b1111;
    localparam logic [3:0] AK_ALLOW_CLR = 4'b0100;

endpackage

// File: rtl/arb_decode.sv
module arb_decode
    import arb_pkg::*;
#(
    parameter int unsigned AW        = 8,
    parameter logic [AW-1:0] MODE_BASE = 8'hB0,
    parameter logic [AW-1:0] FILT_BASE = 8'hC0,
    parameter logic [AW-1:0] FLAG_BASE = 8'hD0
) (
    input  logic [AW-1:0] addr,
    output logic          sel_mode,
    output logic          sel_filt,
    output logic          sel_flag,
    output alias_kind_e   kind
);

    logic aligned;

    always_comb begin
        aligned  = (addr[1:0] == 2'b00);
        sel_mode = aligned && (addr[AW-1:4] == MODE_BASE[AW-1:4]);
        sel_filt = aligned && (addr[AW-1:4] == FILT_BASE[AW-1:4]);
        sel_flag = aligned && (addr[AW-1:4] == FLAG_BASE[AW-1:4]);
        kind     = alias_kind_e'(addr[3:2]);
    end

endmodule

// File: rtl/arb_alias_reg.sv
module arb_alias_reg
    import arb_pkg::*;
#(
    parameter int unsigned   W     = 32,
    parameter logic [W-1:0]  IMPL  = '1,
    parameter logic [W-1:0]  RST   = '0,
    parameter logic [3:0]    ALLOW = AK_ALLOW_ALL
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  alias_kind_e  kind,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] value
);

    typedef struct packed {
        logic [W-1:0] val;
    } reg_st_t;

    reg_st_t      st_d, st_q;
    logic         legal;
    logic [W-1:0] upd;

    always_comb begin
        st_d  = st_q;
        legal = wr_hit && ALLOW[kind];
        upd   = st_q.val;
        if (legal) begin
            unique case (kind)
                AK_PLAIN: upd = wdata;
                AK_SET:   upd = st_q.val | wdata;
                AK_CLR:   upd = st_q.val & ~wdata;
                AK_TGL:   upd = st_q.val ^ wdata;
            endcase
        end
        // Hardware set is applied last, so it overrides a same-cycle clear.
        st_d.val = (upd | hw_set) & IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.val <= RST & IMPL;
        else        st_q     <= st_d;
    end

    assign value = st_q.val;

    AST_PLAIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && kind == AK_PLAIN && ALLOW[0]) |=> (value == ($past(wdata | hw_set) & IMPL))); // R1
    AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && kind == AK_SET && ALLOW[1]) |=> ((value & $past(wdata & IMPL)) == $past(wdata & IMPL))); // R2
    AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && kind == AK_CLR && ALLOW[2]) |=> ((value & $past(wdata & ~hw_set)) == '0)); // R3
    AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> ((value & $past(hw_set & IMPL)) == $past(hw_set & IMPL))); // R8
    AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !ALLOW[kind] && hw_set == '0) |=> $stable(value)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && hw_set == '0) |=> $stable(value)); // R10
    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((value & ~IMPL) == '0)); // R5

endmodule

// File: rtl/alias_reg_bank.sv
module alias_reg_bank
    import arb_pkg::*;
#(
    parameter int unsigned    DW        = 32,
    parameter int unsigned    AW        = 8,
    parameter logic [DW-1:0]  IMPL_MASK = 32'h00FF_FFFF,
    parameter logic [DW-1:0]  MODE_RST  = 32'h0000_0000,
    parameter logic [DW-1:0]  FILT_RST  = 32'hFF00_00A5,
    parameter logic [DW-1:0]  FLAG_RST  = 32'h0000_0000,
    parameter logic [AW-1:0]  MODE_BASE = 8'hB0,
    parameter logic [AW-1:0]  FILT_BASE = 8'hC0,
    parameter logic [AW-1:0]  FLAG_BASE = 8'hD0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] evt_i,
    output logic [DW-1:0] mode_o,
    output logic [DW-1:0] filt_o,
    output logic [DW-1:0] flag_o
);

    typedef struct packed {
        logic [DW-1:0] rdata;
    } rd_st_t;

    rd_st_t      rd_d, rd_q;
    logic        sel_mode, sel_filt, sel_flag;
    alias_kind_e kind;
    logic [DW-1:0] no_hw;

    assign no_hw = '0;

    arb_decode #(
        .AW(AW), .MODE_BASE(MODE_BASE), .FILT_BASE(FILT_BASE), .FLAG_BASE(FLAG_BASE)
    ) u_dec (
        .addr(bus_addr), .sel_mode(sel_mode), .sel_filt(sel_filt),
        .sel_flag(sel_flag), .kind(kind)
    );

    arb_alias_reg #(.W(DW), .IMPL(IMPL_MASK), .RST(MODE_RST), .ALLOW(AK_ALLOW_ALL)) u_mode (
        .clk(clk), .rst_n(rst_n), .wr_hit(bus_wr && sel_mode), .kind(kind),
        .wdata(bus_wdata), .hw_set(no_hw), .value(mode_o)
    );

    arb_alias_reg #(.W(DW), .IMPL(IMPL_MASK), .RST(FILT_RST), .ALLOW(AK_ALLOW_ALL)) u_filt (
        .clk(clk), .rst_n(rst_n), .wr_hit(bus_wr && sel_filt), .kind(kind),
        .wdata(bus_wdata), .hw_set(no_hw), .value(filt_o)
    );

    arb_alias_reg #(.W(DW), .IMPL(IMPL_MASK), .RST(FLAG_RST), .ALLOW(AK_ALLOW_CLR)) u_flag (
        .clk(clk), .rst_n(rst_n), .wr_hit(bus_wr && sel_flag), .kind(kind),
        .wdata(bus_wdata), .hw_set(evt_i), .value(flag_o)
    );

    always_comb begin
        rd_d.rdata = '0;
        if (bus_rd && kind == AK_PLAIN) begin
            if (sel_mode)      rd_d.rdata = mode_o;
            else if (sel_filt) rd_d.rdata = filt_o;
            else if (sel_flag) rd_d.rdata = flag_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q.rdata <= '0;
        else        rd_q       <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;

    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd) |=> (bus_rdata == '0)); // R6
    AST_RD_ALIAS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && kind != AK_PLAIN) |=> (bus_rdata == '0)); // R6
    AST_RD_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !(sel_mode || sel_filt || sel_flag)) |=> (bus_rdata == '0)); // R10
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_mode, sel_filt, sel_flag})); // R10

endmodule

// File: tb/tb_alias_reg_bank.sv
`timescale 1ns/1ps
module tb_alias_reg_bank;

    localparam logic [31:0] IMPL = 32'h00FF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] evt_i = '0;
    logic [31:0] mode_o, filt_o, flag_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] m_mode, m_filt, m_flag;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    alias_reg_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_i(evt_i), .mode_o(mode_o), .filt_o(filt_o), .flag_o(flag_o)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] apply(logic [1:0] k, logic [31:0] q, logic [31:0] w);
        case (k)
            2'd0:    return w & IMPL;
            2'd1:    return (q | w) & IMPL;
            2'd2:    return q & ~w;
            default: return (q ^ w) & IMPL;
        endcase
    endfunction

    // Bench model of a write, optionally with a same-cycle event.
    task automatic model_wr(logic [7:0] a, logic [31:0] d, logic [31:0] ev);
        if (a[1:0] == 2'b00) begin
            if (a[7:4] == 4'hB) m_mode = apply(a[3:2], m_mode, d);
            if (a[7:4] == 4'hC) m_filt = apply(a[3:2], m_filt, d);
            if (a[7:4] == 4'hD && a[3:2] == 2'd2) m_flag = m_flag & ~d;
        end
        m_flag = m_flag | (ev & IMPL);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d, logic [31:0] ev = '0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; evt_i = ev;
        model_wr(a, d, ev);
        @(negedge clk);
        bus_wr = 1'b0; evt_i = '0;
    endtask

    task automatic pulse_evt(logic [31:0] ev);
        @(negedge clk);
        evt_i = ev;
        m_flag = m_flag | (ev & IMPL);
        @(negedge clk);
        evt_i = '0;
    endtask

    // Driver: issues a read and pushes its expected result.
    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_ports(string tag);
        chk({tag, " mode_o"}, mode_o, m_mode);
        chk({tag, " filt_o"}, filt_o, m_filt);
        chk({tag, " flag_o"}, flag_o, m_flag);
    endtask

    always @(posedge clk) rd_seen <= bus_rd;

    // Monitor: pops one expected item for each read, one cycle after the strobe.
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R6 unexpected read result actual=%h expected=none", bus_rdata);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end else if (rst_n && !done) begin
            if (bus_rdata !== 32'h0) begin
                checks++; failures++;
                $display("FAIL R6 idle read data actual=%h expected=00000000", bus_rdata);
            end
        end
    end

    initial begin
        m_mode = 32'h0; m_filt = 32'h0000_00A5; m_flag = 32'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset values, masked
        chk_ports("R9 reset");
        rd(8'hB0, 32'h0000_0000, "R9 mode reset read");
        rd(8'hC0, 32'h0000_00A5, "R9 filt reset read masked");
        rd(8'hD0, 32'h0000_0000, "R9 flag reset read");

        // R1 + R5: plain write drops unimplemented bits
        wr(8'hB0, 32'hFFFF_1234);
        chk_ports("R1 plain write");
        rd(8'hB0, 32'h00FF_1234, "R1 R5 mode read after plain write");

        // R2: set alias
        wr(8'hB4, 32'hF000_000F);
        rd(8'hB0, 32'h00FF_123F, "R2 set alias");
        // R3: clear alias
        wr(8'hB8, 32'h0000_0030);
        rd(8'hB0, 32'h00FF_120F, "R3 clear alias");
        // R4 + R5: toggle alias, upper bits stay 0
        wr(8'hBC, 32'hFF00_FF00);
        rd(8'hB0, 32'h00FF_ED0F, "R4 R5 toggle alias");
        chk_ports("R4 ports");

        // Filter register through all aliases
        wr(8'hC4, 32'h0000_0F00);
        wr(8'hC8, 32'h0000_0005);
        wr(8'hCC, 32'h0001_0001);
        rd(8'hC0, 32'h0001_0FA1, "R2 R3 R4 filter aliases");

        // R6: alias addresses read 0
        rd(8'hB4, 32'h0, "R6 set alias reads 0");
        rd(8'hCC, 32'h0, "R6 toggle alias reads 0");
        rd(8'hD4, 32'h0, "R6 flag dead offset reads 0");

        // R8: hardware events, upper bit unimplemented
        pulse_evt(32'h8000_0003);
        rd(8'hD0, 32'h0000_0003, "R8 R5 event capture");

        // R7: base, set and toggle writes ignored on flags
        wr(8'hD0, 32'h0000_0000);
        wr(8'hD4, 32'h0000_00F0);
        wr(8'hDC, 32'h0000_0003);
        rd(8'hD0, 32'h0000_0003, "R7 flag ignores non-clear writes");
        chk_ports("R7 ports");

        // R3 on flags via 0xD8
        wr(8'hD8, 32'h0000_0002);
        rd(8'hD0, 32'h0000_0001, "R3 R7 flag clear alias");

        // R8: event and clear in the same cycle
        pulse_evt(32'h0000_0006);
        rd(8'hD0, 32'h0000_0007, "R8 events before collision");
        wr(8'hD8, 32'h0000_0006, 32'h0000_0004);
        chk_ports("R8 collision");
        rd(8'hD0, 32'h0000_0005, "R8 hardware set beats clear");

        // R10: unmapped and misaligned accesses
        wr(8'hE0, 32'hFFFF_FFFF);
        wr(8'hA0, 32'hFFFF_FFFF);
        wr(8'hB1, 32'h0000_0000);
        wr(8'hC2, 32'h0000_0000);
        chk_ports("R10 no effect");
        rd(8'hE0, 32'h0, "R10 unmapped read");
        rd(8'hB1, 32'h0, "R10 misaligned read");
        rd(8'hB0, 32'h00FF_ED0F, "R10 mode unchanged");

        // Read and write same cycle: read returns the old value (R6)
        @(negedge clk);
        exp_q.push_back(m_mode); tag_q.push_back("R6 read beside write");
        bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 8'hB0; bus_wdata = 32'h0000_0055;
        model_wr(8'hB0, 32'h0000_0055, 32'h0);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        rd(8'hB0, 32'h0000_0055, "R1 value after concurrent write");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R6 pending reads actual=%0d expected=0", exp_q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule